// File: doc/BRIEF.md
# Oversampled Framed Character Receiver

This block receives a serial bit stream that arrives as one sample per strobe, with a fixed number of samples in every bit period. It waits for a long low start-of-frame, then collects 10-bit characters and writes the 8-bit payload of each into an external frame buffer. A character that is low in every bit ends the frame. Each bit value is taken from one fixed sample position inside the bit period, so short glitches on the other samples have no effect.

The controller is a four-state machine. The states are `ST_UNSYNC`, `ST_SOF_LOW`, `ST_WAIT_START` and `ST_RX_CHAR`. The transitions are:
- `ST_UNSYNC` to `ST_SOF_LOW` when a low sample arrives.
- `ST_SOF_LOW` to `ST_WAIT_START` when the start-of-frame is accepted.
- `ST_SOF_LOW` to `ST_UNSYNC` when the low run is too short or too long.
- `ST_WAIT_START` to `ST_RX_CHAR` when the line falls.
- `ST_WAIT_START` to `ST_UNSYNC` when the idle-high time runs out.
- `ST_RX_CHAR` to `ST_WAIT_START` after a data character is stored.
- `ST_RX_CHAR` to `ST_UNSYNC` after an end character, a malformed character or a full buffer.

The buffer write port, the byte count and the completion pulse let a downstream consumer pick up the frame. That consumer also demodulates the carrier and checks the CRC, since this block does neither.

Top module: `sfr_frame_rx`

## Requirements
- R1: During reset and at the first clock after it, `in_frame`, `frame_done` and `buf_we` are 0, `byte_count` is 0, and the receiver is unsynchronised.
- R2: A clock without `sample_valid` changes neither the state nor `byte_count`.
- R3: In every bit period of 4 samples, counting the falling sample as index 0, the bit value is the sample at index 2. A start-of-frame is accepted, and `in_frame` rises, when that sample is high after 10 to 12 low bits.
- R4: If that sample is high after 9 or fewer low bits, the receiver returns to unsynchronised and `in_frame` stays 0.
- R5: A 13th consecutive low bit in the start-of-frame returns the receiver to unsynchronised, and `in_frame` stays 0.
- R6: While the receiver waits for a start bit, the 26th consecutive high sample ends the frame and `in_frame` falls.
- R7: A character is 10 bits in time order: a start bit that must be 0, 8 data bits with the least significant bit first, then a stop bit that must be 1. A valid character causes one `buf_we` pulse, with `buf_addr` equal to the old `byte_count` and `buf_data` equal to the payload. The pulse comes in the clock after the strobe that carries the stop-bit sample, and `byte_count` increments in that same clock.
- R8: A character whose 10 bits are all 0 ends the frame and drops `in_frame`. `frame_done` pulses for one clock only if `byte_count` is nonzero.
- R9: Any other malformed character ends the frame without a write and without `frame_done`.
- R10: When `byte_count` reaches BUF_DEPTH (64), the frame is aborted. There is no `frame_done`, and `byte_count` stays at 64.
- R11: `byte_count` is cleared when a start-of-frame is accepted, and it holds its value after the frame ends.
- R12: Samples at indices 0, 1 and 3 of a data bit have no effect on the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe: one line sample this clock |
| sample_bit | input | 1 | Line sample value |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | 6 | Frame buffer write address |
| buf_data | output | 8 | Frame buffer write byte |
| byte_count | output | 7 | Bytes stored in the current or last frame |
| frame_done | output | 1 | One-clock pulse at a non-empty frame end |
| in_frame | output | 1 | High from an accepted start-of-frame until the frame ends |

## Verification
The bench drives start-of-frame low runs of 9, 10, 12 and 13 bits. A receiver with an off-by-one limit would either accept the short or long run, or reject 10 or 12. A start-bit wait is driven to exactly 25 and then 26 high samples, which exposes a timeout that fires one sample early or late. Data bits are sent with their non-sampled positions inverted, so a receiver that samples at the wrong index stores corrupted bytes. Further frames cover an empty frame end, a character with a low stop bit and a 64-byte overflow; a wrong receiver would raise a spurious `frame_done` or keep `in_frame` high.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int CHAR_BITS = 10;

    typedef enum logic [1:0] {
        ST_UNSYNC,
        ST_SOF_LOW,
        ST_WAIT_START,
        ST_RX_CHAR
    } rx_state_e;

    typedef enum logic [1:0] {
        CH_DATA,
        CH_EOF,
        CH_BAD
    } char_kind_e;
endpackage

// File: rtl/sfr_ctr.sv
module sfr_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/sfr_char_shift.sv
module sfr_char_shift
    import sfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       bit_in,
    output char_kind_e kind_next,
    output logic [7:0] data_next
);
    logic [CHAR_BITS-1:0] word_q;
    logic [CHAR_BITS-1:0] word_next;

    // newest bit enters at the top; the start bit ends up at bit 0
    assign word_next = {bit_in, word_q[CHAR_BITS-1:1]};
    assign data_next = word_next[8:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= word_next;
    end

    always_comb begin
        if (word_next[CHAR_BITS-1] && !word_next[0]) kind_next = CH_DATA;
        else if (word_next == '0)                    kind_next = CH_EOF;
        else                                         kind_next = CH_BAD;
    end
endmodule

// File: rtl/sfr_frame_rx.sv
module sfr_frame_rx
    import sfr_pkg::*;
#(
    parameter int SAMPLES_PER_BIT = 4,
    parameter int SAMPLE_PHASE    = 2,
    parameter int SOF_MIN_BITS    = 10,
    parameter int SOF_MAX_BITS    = 12,
    parameter int START_WAIT_MAX  = 25,
    parameter int BUF_DEPTH       = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_valid,
    input  logic                         sample_bit,
    output logic                         buf_we,
    output logic [$clog2(BUF_DEPTH)-1:0] buf_addr,
    output logic [7:0]                   buf_data,
    output logic [$clog2(BUF_DEPTH+1)-1:0] byte_count,
    output logic                         frame_done,
    output logic                         in_frame
);
    localparam int IDX_W   = $clog2(SAMPLES_PER_BIT);
    localparam int BIT_LIM = (SOF_MAX_BITS + 1 > CHAR_BITS) ? SOF_MAX_BITS + 1 : CHAR_BITS;
    localparam int BIT_W   = $clog2(BIT_LIM + 1);
    localparam int WAIT_W  = $clog2(START_WAIT_MAX + 1);
    localparam int ADDR_W  = $clog2(BUF_DEPTH);
    localparam int CNT_W   = $clog2(BUF_DEPTH + 1);

    rx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [BIT_W-1:0]  bits_q;
    logic [WAIT_W-1:0] wait_q;
    logic [CNT_W-1:0]  cnt_q;

    logic idx_rst, idx_adv, bits_rst, bits_inc, wait_rst, wait_inc;
    logic shift_en, cnt_clr, cnt_inc, ev_write, ev_done;
    logic at_phase, idx_wrap;
    char_kind_e kind_next;
    logic [7:0] data_next;

    // idx_q holds the index of the previously taken sample of the bit
    sfr_ctr #(.W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n),
        .clr(idx_rst | (idx_adv & idx_wrap)),
        .inc(idx_adv & ~idx_wrap),
        .q(idx_q)
    );

    sfr_ctr #(.W(BIT_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .clr(bits_rst), .inc(bits_inc), .q(bits_q)
    );

    sfr_ctr #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(wait_rst), .inc(wait_inc), .q(wait_q)
    );

    sfr_char_shift u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sample_bit),
        .kind_next(kind_next), .data_next(data_next)
    );

    assign at_phase = (idx_q == IDX_W'(SAMPLE_PHASE - 1));
    assign idx_wrap = (idx_q == IDX_W'(SAMPLES_PER_BIT - 1));

    always_comb begin
        state_d  = state_q;
        idx_rst  = 1'b0;
        idx_adv  = 1'b0;
        bits_rst = 1'b0;
        bits_inc = 1'b0;
        wait_rst = 1'b0;
        wait_inc = 1'b0;
        shift_en = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        ev_write = 1'b0;
        ev_done  = 1'b0;
        unique case (state_q)
            ST_UNSYNC: begin
                if (sample_valid && !sample_bit) begin
                    state_d  = ST_SOF_LOW;
                    idx_rst  = 1'b1;
                    bits_rst = 1'b1;
                end
            end
            ST_SOF_LOW: begin
                if (sample_valid) begin
                    idx_adv = 1'b1;
                    if (at_phase) begin
                        if (sample_bit) begin
                            if (bits_q >= BIT_W'(SOF_MIN_BITS)) begin
                                state_d  = ST_WAIT_START;
                                wait_rst = 1'b1;
                                cnt_clr  = 1'b1;
                            end else begin
                                state_d = ST_UNSYNC;
                            end
                        end else begin
                            bits_inc = 1'b1;
                            if (bits_q == BIT_W'(SOF_MAX_BITS)) state_d = ST_UNSYNC;
                        end
                    end
                end
            end
            ST_WAIT_START: begin
                if (sample_valid) begin
                    if (sample_bit) begin
                        if (wait_q == WAIT_W'(START_WAIT_MAX)) state_d = ST_UNSYNC;
                        else                                   wait_inc = 1'b1;
                    end else begin
                        state_d  = ST_RX_CHAR;
                        idx_rst  = 1'b1;
                        bits_rst = 1'b1;
                    end
                end
            end
            ST_RX_CHAR: begin
                if (sample_valid) begin
                    idx_adv = 1'b1;
                    if (at_phase) begin
                        shift_en = 1'b1;
                        bits_inc = 1'b1;
                        if (bits_q == BIT_W'(CHAR_BITS - 1)) begin
                            case (kind_next)
                                CH_DATA: begin
                                    ev_write = 1'b1;
                                    cnt_inc  = 1'b1;
                                    if (cnt_q == CNT_W'(BUF_DEPTH - 1)) begin
                                        state_d = ST_UNSYNC;
                                    end else begin
                                        state_d  = ST_WAIT_START;
                                        wait_rst = 1'b1;
                                    end
                                end
                                CH_EOF: begin
                                    state_d = ST_UNSYNC;
                                    ev_done = (cnt_q != '0);
                                end
                                default: state_d = ST_UNSYNC;
                            endcase
                        end
                    end
                end
            end
            default: state_d = ST_UNSYNC;
        endcase
    end

    // state register and byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNSYNC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    // registered output events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_we     <= 1'b0;
            buf_addr   <= '0;
            buf_data   <= '0;
            frame_done <= 1'b0;
        end else begin
            buf_we     <= ev_write;
            frame_done <= ev_done;
            if (ev_write) begin
                buf_addr <= cnt_q[ADDR_W-1:0];
                buf_data <= data_next;
            end
        end
    end

    assign byte_count = cnt_q;
    assign in_frame   = (state_q == ST_WAIT_START) || (state_q == ST_RX_CHAR);
endmodule

// File: rtl/sfr_frame_rx_chk.sv
module sfr_frame_rx_chk #(
    parameter int BUF_DEPTH = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sample_valid,
    input logic                           buf_we,
    input logic [$clog2(BUF_DEPTH)-1:0]   buf_addr,
    input logic [$clog2(BUF_DEPTH+1)-1:0] byte_count,
    input logic                           frame_done,
    input logic                           in_frame
);
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    assert_reset_clears_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (byte_count == '0 && !in_frame && !buf_we && !frame_done));

    assert_no_strobe_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(in_frame) && $stable(byte_count)));

    assert_write_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (byte_count == CNT_W'(buf_addr) + CNT_W'(1)));

    assert_write_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(in_frame));

    assert_done_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (byte_count != '0 && !in_frame && $past(in_frame)));

    assert_done_excludes_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && frame_done));

    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CNT_W'(BUF_DEPTH));
endmodule

bind sfr_frame_rx sfr_frame_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .buf_we(buf_we),
    .buf_addr(buf_addr), .byte_count(byte_count), .frame_done(frame_done),
    .in_frame(in_frame)
);

// File: tb/sim_sfr_frame_rx.sv
module sim_sfr_frame_rx;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_valid = 1'b0;
    logic       sample_bit = 1'b1;
    logic       buf_we;
    logic [5:0] buf_addr;
    logic [7:0] buf_data;
    logic [6:0] byte_count;
    logic       frame_done;
    logic       in_frame;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int rises = 0;
    int writes = 0;
    logic prev_in = 1'b0;
    logic [7:0] cap [DEPTH];

    always #10 clk = ~clk;

    sfr_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_bit(sample_bit),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .byte_count(byte_count), .frame_done(frame_done), .in_frame(in_frame)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 sof, 2 waiting, 3 character
    int ms = 0, mpos = 0, mlow = 0, mwait = 0, mbits = 0, mchar = 0, mcnt = 0;
    int e_wr = 0, e_addr = 0, e_data = 0, e_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; e_wr = 0; e_done = 0; e_addr = 0; e_data = 0;
        end else begin
            e_wr = 0; e_done = 0;
            if (sample_valid) begin
                case (ms)
                    0: if (!sample_bit) begin ms = 1; mpos = 0; mlow = 0; end
                    1: begin
                        mpos++;
                        if (mpos % 4 == 2) begin
                            if (sample_bit) begin
                                if (mlow >= 10) begin ms = 2; mwait = 0; mcnt = 0; end
                                else ms = 0;
                            end else begin
                                mlow++;
                                if (mlow > 12) ms = 0;
                            end
                        end
                    end
                    2: if (sample_bit) begin
                           mwait++;
                           if (mwait > 25) ms = 0;
                       end else begin
                           ms = 3; mpos = 0; mbits = 0; mchar = 0;
                       end
                    default: begin
                        mpos++;
                        if (mpos % 4 == 2) begin
                            mchar = (mchar >> 1) | (sample_bit ? 512 : 0);
                            mbits++;
                            if (mbits == 10) begin
                                if ((mchar & 512) != 0 && (mchar & 1) == 0) begin
                                    e_wr = 1; e_addr = mcnt; e_data = (mchar >> 1) & 255;
                                    mcnt++;
                                    if (mcnt >= DEPTH) ms = 0;
                                    else begin ms = 2; mwait = 0; end
                                end else if (mchar == 0) begin
                                    ms = 0;
                                    if (mcnt != 0) e_done = 1;
                                end else ms = 0;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // per-clock comparison and capture, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 in_frame", int'(in_frame), (ms == 2 || ms == 3) ? 1 : 0);
            chk("R11 byte_count", int'(byte_count), mcnt);
            chk("R8 frame_done", int'(frame_done), e_done);
            chk("R7 buf_we", int'(buf_we), e_wr);
            if (e_wr != 0) begin
                chk("R7 buf_addr", int'(buf_addr), e_addr);
                chk("R7 buf_data", int'(buf_data), e_data);
            end
            if (buf_we) begin cap[buf_addr] = buf_data; writes++; end
            if (frame_done) done_seen++;
            if (in_frame && !prev_in) rises++;
            prev_in = in_frame;
        end
    end

    task automatic smp(input logic b);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_bit = b;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic bitv(input logic b, input logic glitch);
        if (glitch) begin smp(~b); smp(~b); smp(b); smp(~b); end
        else repeat (4) smp(b);
    endtask

    task automatic sof(input int nlow);
        for (int i = 0; i < nlow; i++) bitv(1'b0, 1'b0);
        bitv(1'b1, 1'b0);
    endtask

    task automatic chr(input logic [7:0] d, input logic stop, input logic glitch);
        bitv(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) bitv(d[i], glitch);
        bitv(stop, 1'b0);
        bitv(1'b1, 1'b0);
    endtask

    task automatic eof_char();
        for (int i = 0; i < 10; i++) bitv(1'b0, 1'b0);
        bitv(1'b1, 1'b0);
        bitv(1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d0, r0, w0;
        repeat (3) @(negedge clk);
        chk("R1 in_frame in reset", int'(in_frame), 0);
        chk("R1 byte_count in reset", int'(byte_count), 0);
        chk("R1 buf_we in reset", int'(buf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_done after reset", int'(frame_done), 0);

        // basic two-byte frame
        sof(10);
        chk("R3 sof of 10 accepted", int'(in_frame), 1);
        chk("R11 count cleared at sof", int'(byte_count), 0);
        chk_frame_a();

        // glitched data bits, 12-bit sof
        d0 = done_seen;
        sof(12);
        chk("R3 sof of 12 accepted", int'(in_frame), 1);
        chr(8'h00, 1'b1, 1'b1);
        chr(8'hFF, 1'b1, 1'b1);
        chr(8'h96, 1'b1, 1'b1);
        eof_char();
        chk("R12 byte0", int'(cap[0]), 8'h00);
        chk("R12 byte1", int'(cap[1]), 8'hFF);
        chk("R12 byte2", int'(cap[2]), 8'h96);
        chk("R11 count restarted", int'(byte_count), 3);
        chk("R8 done once", done_seen - d0, 1);

        // short sof
        r0 = rises;
        sof(9);
        bitv(1'b1, 1'b0);
        chk("R4 short sof rejected", rises - r0, 0);
        chk("R11 count held", int'(byte_count), 3);

        // long sof
        for (int i = 0; i < 13; i++) bitv(1'b0, 1'b0);
        chk("R5 long sof in_frame", int'(in_frame), 0);
        bitv(1'b1, 1'b0);
        bitv(1'b1, 1'b0);
        chk("R5 long sof rejected", rises - r0, 0);

        // start-bit wait timeout
        sof(10);
        repeat (24) smp(1'b1);
        chk("R6 still waiting at 25", int'(in_frame), 1);
        smp(1'b1);
        chk("R6 timeout at 26", int'(in_frame), 0);

        // no strobe, line low
        sof(11);
        sample_bit = 1'b0;
        repeat (40) @(negedge clk);
        chk("R2 held without strobe", int'(in_frame), 1);
        chk("R2 count held without strobe", int'(byte_count), 0);
        // empty frame end
        d0 = done_seen;
        eof_char();
        chk("R8 empty frame in_frame", int'(in_frame), 0);
        chk("R8 empty frame no done", done_seen - d0, 0);

        // malformed character
        sof(10);
        w0 = writes;
        d0 = done_seen;
        chr(8'h5A, 1'b0, 1'b0);
        chk("R9 bad char ends frame", int'(in_frame), 0);
        chk("R9 bad char no write", writes - w0, 0);
        chk("R9 bad char no done", done_seen - d0, 0);

        // overflow
        sof(10);
        d0 = done_seen;
        for (int i = 0; i < DEPTH; i++) chr(8'(i * 3 + 1), 1'b1, 1'b0);
        chk("R10 overflow ends frame", int'(in_frame), 0);
        chk("R10 overflow count", int'(byte_count), DEPTH);
        chk("R10 last byte", int'(cap[DEPTH-1]), (DEPTH - 1) * 3 + 1);
        chk("R10 no done", done_seen - d0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk_frame_a();
        int d0;
        d0 = done_seen;
        chr(8'hA5, 1'b1, 1'b0);
        chk("R7 first write count", int'(byte_count), 1);
        chr(8'h3C, 1'b1, 1'b0);
        eof_char();
        chk("R7 byte0", int'(cap[0]), 8'hA5);
        chk("R7 byte1", int'(cap[1]), 8'h3C);
        chk("R8 frame ended", int'(in_frame), 0);
        chk("R8 done pulse", done_seen - d0, 1);
        chk("R11 count held after end", int'(byte_count), 2);
    endtask
endmodule